// File: doc/BRIEF.md
# Debounced Panel I/O Register Slave

This block is a small AXI4-Lite register slave that connects a front panel of lamps, colour lamps, slide switches and push buttons to an on-chip bus. Lamp and colour lamp outputs come from writable registers. Switch levels and debounced button levels can be read from one input word. A per-button sticky capture register records every debounced press, so a polling master that reads it only now and then still sees presses that were already over. The master clears captured bits by writing ones to them.

Switch and button pins first pass through two-flop synchronizers. Each button then has its own counter. The counter runs while the synchronized level differs from the accepted level, and the new level is accepted only when the difference has lasted long enough. The counts of lamps, colour lamps, switches and buttons, the debounce length and the address width are all parameters.

Top module: `axil_panel_io`

## Requirements
- R1: After reset, `led_o` and `rgb_o` are zero and the lamp, input, capture and colour registers all read zero while the pins are low.
- R2: Word 0x00 is the lamp register. Bits [NUM_LED-1:0] drive `led_o` and read back. Higher bits read as zero.
- R3: Colour lamp k is held at word 0x0C+4k (0x0C and 0x10 by default). Bit 0 is red, bit 1 is green and bit 2 is blue, and they drive `rgb_o[3k+2:3k]`.
- R4: Writes are byte-strobe masked. Byte lane i of a register changes only when `wstrb[i]` is 1.
- R5: Word 0x04 is read-only. Bits [NUM_SW-1:0] hold the synchronized switches and bits [NUM_SW+NUM_BTN-1:NUM_SW] hold the debounced buttons. A write to this word changes nothing.
- R6: A debounced button takes a new level only after the synchronized input has differed from it for DEBOUNCE_CYCLES consecutive cycles. A shorter excursion is rejected. With DEBOUNCE_CYCLES of 1 or less, the debounced level follows the synchronized input.
- R7: Word 0x08 holds one capture bit per button. The bit is set by a rising edge of the debounced button and stays set after the button is released.
- R8: Writing 1 to a capture bit in a strobed lane clears it. Writing 0, or writing with the lane's strobe low, leaves the bit unchanged.
- R9: When a debounced rising edge and a clear of the same capture bit fall in the same cycle, the bit ends up set.
- R10: Reads of unmapped words return zero and writes to them change nothing. Every B and R response carries OKAY (2'b00).
- R11: The address and the write data may arrive together or in either order. A single B response is issued only after both have arrived. Only one transaction is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awaddr | input | ADDR_W | Write address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response (always OKAY) |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | ADDR_W | Read address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response (always OKAY) |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| led_o | output | NUM_LED | Lamp outputs |
| rgb_o | output | 3*NUM_RGB | Colour lamp outputs, three bits per lamp |
| sw_i | input | NUM_SW | Switch pins |
| btn_i | input | NUM_BTN | Button pins |

## Verification
Two functions can act on the same capture bit in one cycle: the set from a debounced rising edge and the clear from a bus write. To provoke this, the bench presses a button on a known edge and starts a one-ones write to the capture word so that the write commits either one cycle before the rising edge is latched, in the same cycle, or one cycle after. The expected result follows from R9 and R8. The bit must survive the early clear and the coincident clear, and it must be cleared by the late one. A checker property also states that a rise present in one cycle is always visible in the capture register in the next.

// File: rtl/panel_io_pkg.sv
package panel_io_pkg;

  localparam int DW        = 32;
  localparam int NBYTES    = DW / 8;
  localparam int WORD_LED  = 0;
  localparam int WORD_IN   = 1;
  localparam int WORD_EDGE = 2;
  localparam int WORD_RGB0 = 3;
  localparam int RGB_BITS  = 3;

  // Expand byte strobes to a per-bit enable mask.
  function automatic logic [DW-1:0] lane_mask(input logic [NBYTES-1:0] strb);
    logic [DW-1:0] m;
    for (int i = 0; i < NBYTES; i++) begin
      m[i*8 +: 8] = {8{strb[i]}};
    end
    return m;
  endfunction

  // Merge new data into an old word under an enable mask.
  function automatic logic [DW-1:0] masked_merge(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [DW-1:0] m);
    return (old_w & ~m) | (new_w & m);
  endfunction

endpackage

// File: rtl/panel_io_sync.sv
module panel_io_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/panel_io_debounce.sv
module panel_io_debounce #(
  parameter int N      = 4,
  parameter int CYCLES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] stable
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  generate
    if (CYCLES <= 1) begin : g_pass
      always_ff @(posedge clk) begin
        if (!rst_n) stable <= '0;
        else        stable <= raw;
      end
    end else begin : g_cnt
      for (genvar i = 0; i < N; i++) begin : g_bit
        logic [CNT_W-1:0] run_len;
        logic             level;
        assign stable[i] = level;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            run_len <= '0;
            level   <= 1'b0;
          end else if (raw[i] == level) begin
            run_len <= '0;
          end else if (run_len == CNT_W'(CYCLES - 1)) begin
            level   <= raw[i];
            run_len <= '0;
          end else begin
            run_len <= run_len + CNT_W'(1);
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/panel_io_axil_port.sv
module panel_io_axil_port #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [31:0]       wdata,
  input  logic [3:0]        wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [31:0]       rdata,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_strb,
  input  logic [31:0]       rd_word
);
  logic aw_held, w_held;

  assign awready = !aw_held && !bvalid && !rvalid;
  assign wready  = !w_held  && !bvalid && !rvalid;
  assign arready = !aw_held && !w_held && !bvalid && !rvalid && !awvalid && !wvalid;
  assign wr_en   = aw_held && w_held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      bvalid  <= 1'b0;
      rvalid  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_strb <= '0;
      rdata   <= '0;
    end else begin
      if (wr_en) begin
        aw_held <= 1'b0;
        w_held  <= 1'b0;
        bvalid  <= 1'b1;
      end else begin
        if (awvalid && awready) begin
          aw_held <= 1'b1;
          wr_addr <= awaddr;
        end
        if (wvalid && wready) begin
          w_held  <= 1'b1;
          wr_data <= wdata;
          wr_strb <= wstrb;
        end
        if (bvalid && bready) bvalid <= 1'b0;
      end
      if (arvalid && arready) begin
        rvalid <= 1'b1;
        rdata  <= rd_word;
      end else if (rvalid && rready) begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/axil_panel_io.sv
module axil_panel_io
  import panel_io_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int NUM_LED         = 4,
  parameter int NUM_RGB         = 2,
  parameter int NUM_SW          = 4,
  parameter int NUM_BTN         = 4,
  parameter int DEBOUNCE_CYCLES = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    awaddr,
  input  logic                 awvalid,
  output logic                 awready,
  input  logic [31:0]          wdata,
  input  logic [3:0]           wstrb,
  input  logic                 wvalid,
  output logic                 wready,
  output logic [1:0]           bresp,
  output logic                 bvalid,
  input  logic                 bready,
  input  logic [ADDR_W-1:0]    araddr,
  input  logic                 arvalid,
  output logic                 arready,
  output logic [31:0]          rdata,
  output logic [1:0]           rresp,
  output logic                 rvalid,
  input  logic                 rready,
  output logic [NUM_LED-1:0]   led_o,
  output logic [3*NUM_RGB-1:0] rgb_o,
  input  logic [NUM_SW-1:0]    sw_i,
  input  logic [NUM_BTN-1:0]   btn_i
);
  localparam int WW   = ADDR_W - 2;
  localparam int IN_W = NUM_SW + NUM_BTN;

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0]       wr_data;
  logic [3:0]        wr_strb;
  logic [31:0]       rd_word;
  logic [DW-1:0]     wmask;
  logic [WW-1:0]     wr_idx, rd_idx;

  logic [NUM_SW-1:0]  sw_sync;
  logic [NUM_BTN-1:0] btn_sync, btn_db, btn_db_d, btn_rise;
  logic [NUM_BTN-1:0] edge_q, clr_mask;
  logic [NUM_LED-1:0] led_q;
  logic [RGB_BITS-1:0] rgb_q [NUM_RGB];
  logic hit_led, hit_edge;
  logic unused_bits;

  assign bresp = 2'b00;
  assign rresp = 2'b00;

  panel_io_axil_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rvalid(rvalid), .rready(rready),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_word(rd_word)
  );

  panel_io_sync #(.W(NUM_SW)) u_sw_sync (
    .clk(clk), .rst_n(rst_n), .d(sw_i), .q(sw_sync)
  );

  panel_io_sync #(.W(NUM_BTN)) u_btn_sync (
    .clk(clk), .rst_n(rst_n), .d(btn_i), .q(btn_sync)
  );

  panel_io_debounce #(.N(NUM_BTN), .CYCLES(DEBOUNCE_CYCLES)) u_debounce (
    .clk(clk), .rst_n(rst_n), .raw(btn_sync), .stable(btn_db)
  );

  assign wmask    = lane_mask(wr_strb);
  assign wr_idx   = wr_addr[ADDR_W-1:2];
  assign rd_idx   = araddr[ADDR_W-1:2];
  assign hit_led  = wr_en && (wr_idx == WW'(WORD_LED));
  assign hit_edge = wr_en && (wr_idx == WW'(WORD_EDGE));
  assign btn_rise = btn_db & ~btn_db_d;
  assign clr_mask = hit_edge ? (wr_data[NUM_BTN-1:0] & wmask[NUM_BTN-1:0]) : '0;
  assign led_o    = led_q;
  assign unused_bits = ^{wr_data, wmask, wr_addr[1:0], araddr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      led_q    <= '0;
      edge_q   <= '0;
      btn_db_d <= '0;
    end else begin
      if (hit_led) begin
        led_q <= (led_q & ~wmask[NUM_LED-1:0]) | (wr_data[NUM_LED-1:0] & wmask[NUM_LED-1:0]);
      end
      edge_q   <= (edge_q & ~clr_mask) | btn_rise;
      btn_db_d <= btn_db;
    end
  end

  generate
    for (genvar k = 0; k < NUM_RGB; k++) begin : g_rgb
      logic hit_rgb;
      assign hit_rgb = wr_en && (wr_idx == WW'(WORD_RGB0 + k));
      assign rgb_o[RGB_BITS*k +: RGB_BITS] = rgb_q[k];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rgb_q[k] <= '0;
        end else if (hit_rgb) begin
          rgb_q[k] <= (rgb_q[k] & ~wmask[RGB_BITS-1:0]) |
                      (wr_data[RGB_BITS-1:0] & wmask[RGB_BITS-1:0]);
        end
      end
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (rd_idx == WW'(WORD_LED)) begin
      rd_word[NUM_LED-1:0] = led_q;
    end else if (rd_idx == WW'(WORD_IN)) begin
      rd_word[IN_W-1:0] = {btn_db, sw_sync};
    end else if (rd_idx == WW'(WORD_EDGE)) begin
      rd_word[NUM_BTN-1:0] = edge_q;
    end
    for (int k = 0; k < NUM_RGB; k++) begin
      if (rd_idx == WW'(WORD_RGB0 + k)) rd_word[RGB_BITS-1:0] = rgb_q[k];
    end
  end
endmodule

// File: rtl/panel_io_checker.sv
module panel_io_checker #(
  parameter int NUM_LED = 4,
  parameter int NUM_BTN = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bvalid,
  input logic               bready,
  input logic [1:0]         bresp,
  input logic               rvalid,
  input logic               rready,
  input logic [1:0]         rresp,
  input logic               wr_en,
  input logic [NUM_LED-1:0] led_o,
  input logic [NUM_BTN-1:0] edge_q,
  input logic [NUM_BTN-1:0] clr_mask,
  input logic [NUM_BTN-1:0] btn_rise,
  input logic [NUM_BTN-1:0] btn_db,
  input logic [NUM_BTN-1:0] btn_sync
);
  // R10
  bresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00));

  // R10
  rresp_okay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rresp == 2'b00));

  // R11
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);

  // R11
  rvalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> rvalid);

  // R11
  single_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bvalid && rvalid));

  // R2
  led_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(led_o));

  // R7
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & $past(edge_q & ~clr_mask)) == $past(edge_q & ~clr_mask)));

  // R9
  rise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & $past(btn_rise)) == $past(btn_rise)));

  // R6
  db_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((btn_db ^ $past(btn_db)) & ($past(btn_sync) ^ btn_db)) == '0));
endmodule

bind axil_panel_io panel_io_checker #(.NUM_LED(NUM_LED), .NUM_BTN(NUM_BTN)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bvalid(bvalid), .bready(bready), .bresp(bresp),
  .rvalid(rvalid), .rready(rready), .rresp(rresp),
  .wr_en(wr_en), .led_o(led_o),
  .edge_q(edge_q), .clr_mask(clr_mask), .btn_rise(btn_rise),
  .btn_db(btn_db), .btn_sync(btn_sync)
);

// File: tb/axil_panel_io_test.sv
module axil_panel_io_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
  logic        bready = 1'b1, rready = 1'b1;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic [3:0]  led_o;
  logic [5:0]  rgb_o;
  logic [3:0]  sw_i = '0, btn_i = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axil_panel_io #(.ADDR_W(8), .NUM_LED(4), .NUM_RGB(2), .NUM_SW(4), .NUM_BTN(4),
                  .DEBOUNCE_CYCLES(4)) uut (
    .clk(clk), .rst_n(rst_n),
    .awaddr(awaddr), .awvalid(awvalid), .awready(awready),
    .wdata(wdata), .wstrb(wstrb), .wvalid(wvalid), .wready(wready),
    .bresp(bresp), .bvalid(bvalid), .bready(bready),
    .araddr(araddr), .arvalid(arvalid), .arready(arready),
    .rdata(rdata), .rresp(rresp), .rvalid(rvalid), .rready(rready),
    .led_o(led_o), .rgb_o(rgb_o), .sw_i(sw_i), .btn_i(btn_i)
  );

  // {write addr, write data, strobes, read addr, expected read}
  localparam logic [83:0] VECS [NVEC] = '{
    {8'h00, 32'h0000000A, 4'hF, 8'h00, 32'h0000000A},
    {8'h0C, 32'h00000005, 4'hF, 8'h0C, 32'h00000005},
    {8'h10, 32'h00000003, 4'hF, 8'h10, 32'h00000003},
    {8'h00, 32'hFFFFFFFF, 4'hF, 8'h00, 32'h0000000F},
    {8'h00, 32'h00000000, 4'h0, 8'h00, 32'h0000000F},
    {8'h00, 32'h00000005, 4'h2, 8'h00, 32'h0000000F},
    {8'h00, 32'h00000005, 4'h1, 8'h00, 32'h00000005},
    {8'h04, 32'hFFFFFFFF, 4'hF, 8'h04, 32'h00000009},
    {8'h40, 32'h12345678, 4'hF, 8'h40, 32'h00000000},
    {8'h14, 32'h0000FFFF, 4'hF, 8'h14, 32'h00000000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // mode 0: address and data together, 1: address first, 2: data first
  task automatic do_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                          input int mode, output logic [1:0] resp);
    bit aw_left = 1'b1, w_left = 1'b1, aw_hs, w_hs;
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s;
    if (mode != 2) awvalid = 1'b1;
    if (mode != 1) wvalid = 1'b1;
    while (aw_left || w_left) begin
      #1;
      aw_hs = awvalid && awready;
      w_hs  = wvalid && wready;
      @(negedge clk);
      if (aw_hs) begin awvalid = 1'b0; aw_left = 1'b0; end
      if (w_hs)  begin wvalid = 1'b0;  w_left = 1'b0;  end
      if (!aw_left && w_left && !wvalid) begin
        repeat (2) @(negedge clk);
        check("R11 no B before data", {31'b0, bvalid}, 32'h0);
        wvalid = 1'b1;
      end
      if (!w_left && aw_left && !awvalid) begin
        repeat (2) @(negedge clk);
        check("R11 no B before address", {31'b0, bvalid}, 32'h0);
        awvalid = 1'b1;
      end
    end
    #1;
    while (!bvalid) begin @(negedge clk); #1; end
    resp = bresp;
    @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d, output logic [1:0] resp);
    bit hs;
    @(negedge clk);
    araddr = a; arvalid = 1'b1;
    do begin #1; hs = arready; @(negedge clk); end while (!hs);
    arvalid = 1'b0;
    #1;
    while (!rvalid) begin @(negedge clk); #1; end
    d = rdata; resp = rresp;
    @(negedge clk);
  endtask

  task automatic read_expect(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d; logic [1:0] r;
    do_read(a, d, r);
    check(tag, d, exp);
  endtask

  task automatic write_plain(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    logic [1:0] r;
    do_write(a, d, s, 0, r);
  endtask

  // Press button 2, then commit a clear of its capture bit a chosen number of cycles later.
  task automatic race_trial(input int dly, input logic [31:0] exp, input string tag);
    @(negedge clk);
    btn_i[2] = 1'b1;
    repeat (dly) @(negedge clk);
    awaddr = 8'h08; wdata = 32'h4; wstrb = 4'hF; awvalid = 1'b1; wvalid = 1'b1;
    @(negedge clk);
    awvalid = 1'b0; wvalid = 1'b0;
    #1;
    while (!bvalid) begin @(negedge clk); #1; end
    @(negedge clk);
    read_expect(tag, 8'h08, exp);
    btn_i[2] = 1'b0;
    repeat (12) @(negedge clk);
    write_plain(8'h08, 32'hF, 4'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [1:0]  r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 led_o", {28'b0, led_o}, 32'h0);
    check("R1 rgb_o", {26'b0, rgb_o}, 32'h0);
    read_expect("R1 lamp reg", 8'h00, 32'h0);
    read_expect("R1 input reg", 8'h04, 32'h0);
    read_expect("R1 capture reg", 8'h08, 32'h0);
    read_expect("R1 colour reg", 8'h0C, 32'h0);

    sw_i = 4'h9;
    repeat (4) @(negedge clk);

    // R2 R3 R4 R5 R10 R11 table
    for (int i = 0; i < NVEC; i++) begin
      logic [83:0] v;
      v = VECS[i];
      do_write(v[83:76], v[75:44], v[43:40], i % 3, r);
      check($sformatf("R10 bresp vec%0d", i), {30'b0, r}, 32'h0);
      do_read(v[39:32], d, r);
      check($sformatf("R10 rresp vec%0d", i), {30'b0, r}, 32'h0);
      check($sformatf("R2/R3/R4/R5/R10 vec%0d", i), d, v[31:0]);
    end
    check("R2 led_o pins", {28'b0, led_o}, 32'h5);
    check("R3 rgb_o pins", {26'b0, rgb_o}, 32'h1D);

    // R7 capture and sticky
    btn_i[1] = 1'b1;
    repeat (10) @(negedge clk);
    read_expect("R7 capture on press", 8'h08, 32'h2);
    read_expect("R5 debounced button level", 8'h04, 32'h29);
    btn_i[1] = 1'b0;
    repeat (10) @(negedge clk);
    read_expect("R7 sticky after release", 8'h08, 32'h2);
    read_expect("R5 button released", 8'h04, 32'h09);

    // R8 clear semantics
    write_plain(8'h08, 32'h0, 4'hF);
    read_expect("R8 zero write keeps", 8'h08, 32'h2);
    write_plain(8'h08, 32'h2, 4'h0);
    read_expect("R8 no strobe keeps", 8'h08, 32'h2);
    write_plain(8'h08, 32'h2, 4'hF);
    read_expect("R8 one write clears", 8'h08, 32'h0);

    // R6 glitch of DEBOUNCE_CYCLES-1 cycles rejected
    @(negedge clk); btn_i[0] = 1'b1;
    repeat (3) @(negedge clk); btn_i[0] = 1'b0;
    repeat (10) @(negedge clk);
    read_expect("R6 short pulse rejected", 8'h08, 32'h0);
    read_expect("R6 level unchanged", 8'h04, 32'h09);

    // R6 pulse of exactly DEBOUNCE_CYCLES cycles accepted
    @(negedge clk); btn_i[0] = 1'b1;
    repeat (4) @(negedge clk); btn_i[0] = 1'b0;
    repeat (12) @(negedge clk);
    read_expect("R6 full-length pulse accepted", 8'h08, 32'h1);
    write_plain(8'h08, 32'h1, 4'hF);
    read_expect("R8 cleared after R6", 8'h08, 32'h0);

    // R9 set and clear in the same cycle; neighbours as reference
    race_trial(4, 32'h4, "R9 clear one cycle early");
    race_trial(5, 32'h4, "R9 clear in same cycle");
    race_trial(6, 32'h0, "R8 clear one cycle late");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule